// File: doc/BRIEF.md
# Dual-Clock Handshake Buffer

This block moves data words in one direction between a transmitting logic island and a receiving logic island whose clocks have no fixed relation to each other. The transmitter offers a word by raising a one-cycle `put` strobe with the word on `data_in`. The receiver reads `data_out` and raises a one-cycle `take` strobe to remove that word. Each side has its own clock and its own active-low reset.

Each status output works as a per-transfer handshake and not as a level flag. After an accepted `put`, `ok_to_put` goes low. It comes back only once the block confirms there is room for another word. After an accepted `take`, `ok_to_take` goes low. It comes back only once the block confirms there is another word to read. Read and write positions are counted in Gray code. Each position reaches the opposite clock through a two-stage synchronizer. The storage depth is a power-of-two parameter and can be as small as one word.

Top module: `hs_cdc_fifo`

## Requirements
- R1: A `put` sampled high on a rising `wclk` edge while `ok_to_put` is high stores `data_in` as the newest word.
- R2: In the `wclk` cycle after an accepted put, `ok_to_put` is low.
- R3: Once DEPTH words are stored, `ok_to_put` stays low until a word has been taken. It then returns high within a bounded number of `wclk` cycles.
- R4: While `ok_to_take` is high, at least one word is stored and `data_out` shows the oldest stored word. After a write into an empty buffer, `ok_to_take` rises within a bounded number of `rclk` cycles.
- R5: In the `rclk` cycle after an accepted take, `ok_to_take` is low. It stays low for as long as the buffer is empty.
- R6: Words leave in the order they entered, with none lost and none repeated, while the two clocks run at unrelated rates.
- R7: A `put` while `ok_to_put` is low, or a `take` while `ok_to_take` is low, has no effect. The stored words and the order of later reads are unchanged.
- R8: With DEPTH = 1 the block still transfers correctly. After each put, `ok_to_put` stays low until that word has been taken.
- R9: While `wrst_n` is low, `ok_to_put` is low. While `rrst_n` is low, `ok_to_take` is low. After both resets release, the buffer is empty, `ok_to_put` is high and `ok_to_take` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Transmitter clock |
| wrst_n | input | 1 | Transmitter-side reset, active low, asynchronous |
| put | input | 1 | Write strobe, one cycle per word |
| data_in | input | WIDTH | Word to write |
| ok_to_put | output | 1 | Room is confirmed and a put will be accepted |
| rclk | input | 1 | Receiver clock |
| rrst_n | input | 1 | Receiver-side reset, active low, asynchronous |
| take | input | 1 | Read strobe, one cycle per word |
| data_out | output | WIDTH | Oldest stored word |
| ok_to_take | output | 1 | A word is confirmed and a take will be accepted |

## Verification
The bench builds two copies of the block. The first uses WIDTH = 8 and DEPTH = 4, so the pointer wraps several times and the full condition compares the top two Gray bits. The second uses DEPTH = 1, where the pointer is a single bit and the buffer fills on every put. The two clocks run at 5 ns and 7.3 ns, so the synchronized pointer is sampled in a different phase on each transfer. Strobes are applied deliberately while a status is low, to show that they are ignored.

// File: rtl/hs_cdc_fifo.sv
module hs_cdc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             put,
  input  logic [WIDTH-1:0] data_in,
  output logic             ok_to_put,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             take,
  output logic [WIDTH-1:0] data_out,
  output logic             ok_to_take
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int IW = (AW > 0) ? AW : 1;
  localparam logic [PW-1:0] FMASK = (PW == 1) ? PW'(1) : (PW'(3) << (PW - 2));

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic [PW-1:0] rbin, rgray, wq1, wq2;

  wire put_ok  = put & ok_to_put;
  wire take_ok = take & ok_to_take;
  wire [PW-1:0] wbin_n = wbin + PW'(1);
  wire [PW-1:0] rbin_n = rbin + PW'(1);
  wire [IW-1:0] waddr = wbin[IW-1:0] & IW'(DEPTH - 1);
  wire [IW-1:0] raddr = rbin[IW-1:0] & IW'(DEPTH - 1);
  wire full  = ((wgray ^ rq2) == FMASK);
  wire empty = (rgray == wq2);

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0; ok_to_put <= 1'b0;
    end else begin
      if (put_ok) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
      rq1 <= rgray;
      rq2 <= rq1;
      ok_to_put <= !put_ok && !full;
    end

  always_ff @(posedge wclk)
    if (put_ok) mem[waddr] <= data_in;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0; ok_to_take <= 1'b0;
    end else begin
      if (take_ok) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
      wq1 <= wgray;
      wq2 <= wq1;
      ok_to_take <= !take_ok && !empty;
    end

  assign data_out = mem[raddr];
endmodule

// File: rtl/hs_cdc_fifo_chk.sv
module hs_cdc_fifo_chk #(
  parameter int PW = 3,
  parameter logic [PW-1:0] FMASK = '1
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          put,
  input logic          take,
  input logic          ok_to_put,
  input logic          ok_to_take,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] wq2,
  input logic [PW-1:0] rq2
);
  a_r2_put_drops: assert property (@(posedge wclk) disable iff (!wrst_n)
    (put && ok_to_put) |=> !ok_to_put);
  a_r5_take_drops: assert property (@(posedge rclk) disable iff (!rrst_n)
    (take && ok_to_take) |=> !ok_to_take);
  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
    ok_to_put |-> ((wgray ^ rq2) != FMASK));
  a_r4_take_has_data: assert property (@(posedge rclk) disable iff (!rrst_n)
    ok_to_take |-> (rgray != wq2));
  a_r7_idle_put_holds: assert property (@(posedge wclk) disable iff (!wrst_n)
    !(put && ok_to_put) |=> $stable(wgray));
  a_r7_idle_take_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(take && ok_to_take) |=> $stable(rgray));
  a_r6_wgray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r6_rgray_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind hs_cdc_fifo hs_cdc_fifo_chk #(.PW(PW), .FMASK(FMASK)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .put(put), .take(take), .ok_to_put(ok_to_put), .ok_to_take(ok_to_take),
  .wgray(wgray), .rgray(rgray), .wq2(wq2), .rq2(rq2));

// File: tb/hs_cdc_fifo_tb.sv
`timescale 1ns/100ps
module hs_cdc_fifo_tb;
  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  always #2.5 wclk = ~wclk;
  always #3.65 rclk = ~rclk;

  logic put = 0, take = 0;
  logic [7:0] data_in = 0, data_out;
  logic ok_to_put, ok_to_take;
  logic p1 = 0, t1 = 0, ok1, okt1;
  logic [7:0] d1 = 0, q1;

  hs_cdc_fifo #(.WIDTH(8), .DEPTH(4)) u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .put(put), .data_in(data_in), .ok_to_put(ok_to_put),
    .rclk(rclk), .rrst_n(rrst_n), .take(take), .data_out(data_out), .ok_to_take(ok_to_take));
  hs_cdc_fifo #(.WIDTH(8), .DEPTH(1)) u_one (
    .wclk(wclk), .wrst_n(wrst_n), .put(p1), .data_in(d1), .ok_to_put(ok1),
    .rclk(rclk), .rrst_n(rrst_n), .take(t1), .data_out(q1), .ok_to_take(okt1));

  int checks = 0, fails = 0;
  logic [7:0] sb[$];
  bit rd_en = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put4(input logic [7:0] d);
    @(negedge wclk);
    while (!ok_to_put) @(negedge wclk);
    put = 1; data_in = d; sb.push_back(d);
    @(negedge wclk);
    put = 0;
    chk(ok_to_put == 0, "R2", ok_to_put, 0);
  endtask

  // scoreboard monitor on the read side
  initial forever begin
    @(negedge rclk);
    if (rd_en && ok_to_take) begin
      if (sb.size() == 0) chk(0, "R6 extra word", data_out, 0);
      else begin
        logic [7:0] e;
        e = sb.pop_front();
        chk(data_out == e, "R4/R6 data", data_out, e);
      end
      take = 1;
      @(negedge rclk);
      take = 0;
      chk(ok_to_take == 0, "R5", ok_to_take, 0);
    end
  end

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge wclk);
    chk(ok_to_put == 0 && ok1 == 0, "R9 wreset", ok_to_put, 0);
    chk(ok_to_take == 0 && okt1 == 0, "R9 rreset", ok_to_take, 0);
    wrst_n = 1;
    repeat (2) @(negedge rclk);
    chk(ok_to_take == 0, "R9 rreset held", ok_to_take, 0);
    rrst_n = 1;
    repeat (6) @(negedge wclk);
    chk(ok_to_put == 1, "R9 put ready", ok_to_put, 1);
    chk(ok_to_take == 0, "R9 empty", ok_to_take, 0);

    // R1/R6: streaming with reader active
    rd_en = 1;
    for (int i = 0; i < 20; i++) put4(8'(i * 13 + 5));
    n = 0;
    while (sb.size() != 0 && n < 200) begin @(negedge rclk); n++; end
    chk(sb.size() == 0, "R1/R6 drained", sb.size(), 0);
    repeat (4) @(negedge rclk);

    // R3: fill with reader idle
    rd_en = 0;
    for (int i = 0; i < 4; i++) put4(8'hA0 + 8'(i));
    repeat (12) @(negedge wclk);
    chk(ok_to_put == 0, "R3 full holds", ok_to_put, 0);
    // R7: put while not ok is ignored
    put = 1; data_in = 8'hEE;
    @(negedge wclk); put = 0;
    repeat (3) @(negedge wclk);
    chk(ok_to_put == 0, "R7 ignored put", ok_to_put, 0);
    rd_en = 1;
    n = 0;
    while (!ok_to_put && n < 40) begin @(negedge wclk); n++; end
    chk(ok_to_put == 1, "R3 room returns", ok_to_put, 1);
    n = 0;
    while (sb.size() != 0 && n < 200) begin @(negedge rclk); n++; end
    repeat (10) @(negedge rclk);
    chk(ok_to_take == 0, "R5 empty holds", ok_to_take, 0);

    // R7: take while not ok is ignored
    rd_en = 0;
    @(negedge rclk); take = 1;
    @(negedge rclk); take = 0;
    put4(8'h5C);
    n = 0;
    while (!ok_to_take && n < 20) begin @(negedge rclk); n++; end
    chk(ok_to_take == 1, "R4 data arrives", ok_to_take, 1);
    chk(data_out == 8'h5C, "R7 ignored take", data_out, 8'h5C);
    rd_en = 1;
    n = 0;
    while (sb.size() != 0 && n < 50) begin @(negedge rclk); n++; end
    rd_en = 0;

    // R8: depth of one
    for (int k = 0; k < 3; k++) begin
      logic [7:0] v;
      v = 8'h31 + 8'(k * 7);
      @(negedge wclk);
      while (!ok1) @(negedge wclk);
      p1 = 1; d1 = v;
      @(negedge wclk); p1 = 0;
      repeat (12) @(negedge wclk);
      chk(ok1 == 0, "R8 full after one", ok1, 0);
      @(negedge rclk);
      while (!okt1) @(negedge rclk);
      chk(q1 == v, "R8 data", q1, v);
      t1 = 1;
      @(negedge rclk); t1 = 0;
      chk(okt1 == 0, "R8 take drops", okt1, 0);
      n = 0;
      while (!ok1 && n < 40) begin @(negedge wclk); n++; end
      chk(ok1 == 1, "R8 room returns", ok1, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule